// File: doc/BRIEF.md
# Sticky Communication and Memory Fault Status Byte

This block holds one byte of latched fault flags for a power-management bus slave. Other logic sends it single-cycle event pulses: a bad command code, bad data bytes, a packet-error-check failure, an internal memory fault, and any other communication fault such as a bus clock-low timeout or a lost link to the power stage. Each pulse sets its own flag. The flag then stays set after the cause has gone away, until something clears it.

There are three clear paths, and each one takes effect on the next clock edge:
- a register write, where each 1 clears the matching flag;
- a clear-faults strobe, which clears every flag;
- a rail on/off toggle event, which also clears every flag.

A power cycle is covered by the reset.

The block has three outputs:
- a summary bit, which the top-level status byte uses;
- an active-low alert request, which ignores any flag whose mask bit is 1;
- a combinational read port, which returns the current byte and has no side effect on it.

Top module: `cml_status_reg`

## Requirements
- R1: Each event pulse sets its flag at the next rising clock edge. The bit positions are: bit 7 for a bad command, bit 6 for bad data, bit 5 for a packet-error-check failure, bit 4 for a memory fault, and bit 1 for other communication faults.
- R2: Bits 3, 2 and 0 are reserved. They always read 0, and writing 1 to them has no effect.
- R3: After reset, every bit of the byte is 0, the summary is 0 and `alert_n` is 1.
- R4: A set flag stays set in every later cycle that has no clear for it, whether or not its event is present.
- R5: When `wr_en` is 1, each 1 in `wr_data` clears the flag at that position on the next edge. Each 0 leaves its flag unchanged.
- R6: A pulse on `clr_all` clears every flag on the next edge.
- R7: A pulse on `rail_toggle` clears every flag on the next edge.
- R8: `summary` is 1 exactly when at least one flag is 1.
- R9: A flag whose `alert_mask` bit is 1 still latches and still shows in `status_q` and in `summary`, but it does not drive the alert request.
- R10: If a set event and any clear for the same flag arrive in the same cycle, the flag ends up set.
- R11: `alert_n` is 0 exactly while at least one latched flag has its mask bit at 0. Only bits allowed by the parameter `ALERT_CAPABLE` can drive it.
- R12: `rd_data` equals `status_q` while `rd_en` is 1 and is 0 otherwise. Reading changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bad_cmd | input | 1 | Pulse: unsupported command code |
| evt_bad_data | input | 1 | Pulse: unsupported or invalid data |
| evt_pec_err | input | 1 | Pulse: packet error check failed |
| evt_mem_err | input | 1 | Pulse: internal memory fault |
| evt_other_comm | input | 1 | Pulse: other communication fault |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write-one-to-clear data |
| clr_all | input | 1 | Clear-faults strobe |
| rail_toggle | input | 1 | Rail on/off toggle event |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data |
| alert_mask | input | 8 | 1 = bit excluded from alert |
| status_q | output | 8 | Latched status byte |
| summary | output | 1 | OR of all flags |
| alert_n | output | 1 | Active-low alert request |

## Verification
The bench uses the default `ALERT_CAPABLE` value. In that build all five implemented flags can raise the alert, so every mask bit is observable through `alert_n`, including the case where every set flag is masked. The default build also exposes reserved-bit writes, the same-cycle collisions between a set and each of the three clear paths, and an all-ones write.

// File: rtl/cml_status_pkg.sv
package cml_status_pkg;
  localparam int unsigned STAT_W = 8;

  // Bit positions are decoded by the top-level status logic and host firmware.
  localparam int unsigned POS_BAD_CMD  = 7;
  localparam int unsigned POS_BAD_DATA = 6;
  localparam int unsigned POS_PEC_ERR  = 5;
  localparam int unsigned POS_MEM_ERR  = 4;
  localparam int unsigned POS_OTH_COMM = 1;

  localparam logic [STAT_W-1:0] IMPL_BITS =
      (STAT_W'(1) << POS_BAD_CMD)  | (STAT_W'(1) << POS_BAD_DATA) |
      (STAT_W'(1) << POS_PEC_ERR)  | (STAT_W'(1) << POS_MEM_ERR)  |
      (STAT_W'(1) << POS_OTH_COMM);

  typedef struct packed {
    logic bad_cmd;
    logic bad_data;
    logic pec_err;
    logic mem_err;
    logic oth_comm;
  } cml_evt_t;

  function automatic logic [STAT_W-1:0] evt_to_vec(input cml_evt_t e);
    logic [STAT_W-1:0] v;
    v = '0;
    v[POS_BAD_CMD]  = e.bad_cmd;
    v[POS_BAD_DATA] = e.bad_data;
    v[POS_PEC_ERR]  = e.pec_err;
    v[POS_MEM_ERR]  = e.mem_err;
    v[POS_OTH_COMM] = e.oth_comm;
    return v;
  endfunction
endpackage

// File: rtl/cml_sticky_cell.sv
module cml_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // a set beats any clear in the same cycle
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/cml_clear_ctrl.sv
module cml_clear_ctrl #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_all,
  input  logic         rail_toggle,
  output logic [W-1:0] clr_vec
);
  logic [W-1:0] w1c_vec;
  logic         bulk;

  always_comb begin
    w1c_vec = wr_en ? wr_data : '0;
    bulk    = clr_all | rail_toggle;
    clr_vec = (w1c_vec | {W{bulk}}) & IMPL;
  end

  always_comb begin
    if (clr_all) a_bulk_r6: assert (clr_vec == IMPL);
    if (rail_toggle) a_bulk_r7: assert (clr_vec == IMPL);
  end
endmodule

// File: rtl/cml_alert_gen.sv
module cml_alert_gen #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] CAPABLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] set_vec,
  output logic         summary,
  output logic         alert_n
);
  logic [W-1:0] live;

  always_comb begin
    live    = stat & ~mask & CAPABLE;
    summary = |stat;
    alert_n = ~(|live);
  end

  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(summary) |-> $past(|set_vec));
  p_alert_needs_summary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> summary);
endmodule

// File: rtl/cml_status_reg.sv
module cml_status_reg
  import cml_status_pkg::*;
#(
  parameter logic [7:0] ALERT_CAPABLE = 8'hF2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_bad_cmd,
  input  logic       evt_bad_data,
  input  logic       evt_pec_err,
  input  logic       evt_mem_err,
  input  logic       evt_other_comm,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_all,
  input  logic       rail_toggle,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic [7:0] alert_mask,
  output logic [7:0] status_q,
  output logic       summary,
  output logic       alert_n
);
  localparam int unsigned W = STAT_W;

  cml_evt_t     evt;
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] stat;

  always_comb begin
    evt.bad_cmd  = evt_bad_cmd;
    evt.bad_data = evt_bad_data;
    evt.pec_err  = evt_pec_err;
    evt.mem_err  = evt_mem_err;
    evt.oth_comm = evt_other_comm;
    set_vec      = evt_to_vec(evt);
  end

  cml_clear_ctrl #(.W(W), .IMPL(IMPL_BITS)) u_clr (
    .wr_en(wr_en), .wr_data(wr_data), .clr_all(clr_all),
    .rail_toggle(rail_toggle), .clr_vec(clr_vec)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL_BITS[b]) begin : g_impl
      cml_sticky_cell u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[b]),
        .clr_i(clr_vec[b]), .q_o(stat[b])
      );
    end else begin : g_rsvd
      assign stat[b] = 1'b0;
    end
  end

  cml_alert_gen #(.W(W), .CAPABLE(ALERT_CAPABLE & IMPL_BITS)) u_alert (
    .clk(clk), .rst_n(rst_n), .stat(stat), .mask(alert_mask),
    .set_vec(set_vec), .summary(summary), .alert_n(alert_n)
  );

  assign status_q = stat;
  assign rd_data  = rd_en ? stat : '0;

  p_read_no_effect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !clr_all && !rail_toggle && !(|set_vec)) |=> $stable(status_q));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|(wr_data & ~IMPL_BITS))) |=> ((status_q & ~IMPL_BITS) == '0));
endmodule

// File: tb/cml_status_reg_test.sv
module cml_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] evt = '0;   // {bad_cmd, bad_data, pec, mem, other}
  logic wr_en = 1'b0, clr_all = 1'b0, rail_toggle = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, alert_mask = '0;
  logic [7:0] rd_data, status_q;
  logic summary, alert_n;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cml_status_reg uut (
    .clk(clk), .rst_n(rst_n),
    .evt_bad_cmd(evt[4]), .evt_bad_data(evt[3]), .evt_pec_err(evt[2]),
    .evt_mem_err(evt[1]), .evt_other_comm(evt[0]),
    .wr_en(wr_en), .wr_data(wr_data), .clr_all(clr_all),
    .rail_toggle(rail_toggle), .rd_en(rd_en), .rd_data(rd_data),
    .alert_mask(alert_mask), .status_q(status_q), .summary(summary),
    .alert_n(alert_n)
  );

  // {evt5, wr_en, wr_data8, clr, tog, mask8, exp_stat8, exp_sum, exp_alert_n}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {5'b10000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0}, // R1 cmd
    {5'b00010, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b1, 1'b0}, // R1 mem
    {5'b00000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h80, 8'h90, 1'b1, 1'b0}, // R4 R11
    {5'b00000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h90, 8'h90, 1'b1, 1'b1}, // R9
    {5'b00000, 1'b1, 8'h80, 1'b0, 1'b0, 8'h00, 8'h10, 1'b1, 1'b0}, // R5
    {5'b00000, 1'b1, 8'h0F, 1'b0, 1'b0, 8'h00, 8'h10, 1'b1, 1'b0}, // R2 R5
    {5'b01001, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h52, 1'b1, 1'b0}, // R1 data+other
    {5'b00000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R6
    {5'b00100, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h20, 1'b1, 1'b0}, // R10 vs R6
    {5'b01000, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h40, 1'b1, 1'b0}, // R10 vs R7
    {5'b01000, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 1'b0}, // R10 vs R5
    {5'b00000, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R5 all
    {5'b11111, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'hF2, 1'b1, 1'b0}, // R1 all
    {5'b00000, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1}  // R7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    evt = '0; wr_en = 1'b0; wr_data = '0; clr_all = 1'b0; rail_toggle = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R3 status", status_q, 8'h00);
    chk("R3 summary", {7'd0, summary}, 8'h00);
    chk("R3 alert_n", {7'd0, alert_n}, 8'h01);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt = VEC[i][33:29]; wr_en = VEC[i][28]; wr_data = VEC[i][27:20];
      clr_all = VEC[i][19]; rail_toggle = VEC[i][18]; alert_mask = VEC[i][17:10];
      cycle();
      chk($sformatf("R1/R4 vec%0d status", i), status_q, VEC[i][9:2]);
      chk($sformatf("R8 vec%0d summary", i), {7'd0, summary}, {7'd0, VEC[i][1]});
      chk($sformatf("R11 vec%0d alert_n", i), {7'd0, alert_n}, {7'd0, VEC[i][0]});
    end

    // R12: read port and no side effect
    @(negedge clk); evt = 5'b10100; alert_mask = 8'h00; cycle();
    chk("R12 rd_en low", rd_data, 8'h00);
    rd_en = 1'b1; #0.5;
    chk("R12 rd_en high", rd_data, 8'hA0);
    cycle(); cycle();
    chk("R12 repeated read", rd_data, 8'hA0);
    rd_en = 1'b0;

    // R9: masked bit keeps latching while alert stays off
    @(negedge clk); alert_mask = 8'hFF; evt = 5'b00001; cycle();
    chk("R9 masked latch", status_q, 8'hA2);
    chk("R9 masked alert", {7'd0, alert_n}, 8'h01);
    alert_mask = 8'h00; #0.5;
    chk("R11 unmask", {7'd0, alert_n}, 8'h00);

    // R2: reserved bits stay zero under writes
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h0D; cycle();
    chk("R2 reserved write", status_q, 8'hA2);

    // R3: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R3 async reset", status_q, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule